// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer controlled through one 32-bit register on a simple valid/write/address port. Software selects a timeout from a ladder of values with two 2-bit fields. The first is a clock divider select with unequal steps between its settings. The second is an interval select in which each step is four times the one before. Software keeps the watchdog alive by writing the register with the restart bit set. The usual way to do this is read-modify-write, so that all the other fields keep their values.

If the count reaches its limit, the block first sets an interrupt flag. This flag serves as a pre-timeout warning and drives the interrupt line when interrupts are enabled. After a fixed number of base prescaler ticks, and only if reset is enabled, the block drives the system reset output for a set number of clock cycles. It records that event in a sticky reset flag and then stops counting. Reading the register shows whether the watchdog is running, so boot code can tell that it was left enabled.

The base prescale, divider step, interval base, warning-to-reset delay and reset pulse length are all parameters. A short simulation keeps the same ratios between timeouts as the full-size configuration. A build option removes the interrupt path.

Top module: `wdog_core`

## Requirements
- R1: After power-on reset the register reads 0x00000000 and both `irq_o` and `sys_rst_o` are low.
- R2: The register holds these fields: enable in bit 7, divider select in bits 11:10, interval select in bits 5:4, interrupt enable in bit 6, reset enable in bit 1, interrupt flag in bit 3 and reset flag in bit 2. Every other bit, bit 0 included, reads as zero. A write loads enable, divider select, interval select, interrupt enable and reset enable.
- R3: A write with bit 0 set restarts the count from zero. Writing the current value with bit 0 set at intervals shorter than the timeout keeps the interrupt flag clear.
- R4: While enabled, the interrupt flag sets exactly BASE_DIV × ratio × INTERVAL_BASE × 4^interval clock edges after the restarting write edge. The ratio is 1, STEP01, 8·STEP01 and 256·STEP01 for divider selects 00, 01, 10 and 11.
- R5: `irq_o` is high exactly when the interrupt flag, interrupt enable and enable are all set.
- R6: If reset enable is set, `sys_rst_o` rises RST_DELAY × BASE_DIV clock edges after the interrupt flag sets. It stays high for RST_HOLD cycles, the reset flag sets, and enable then reads 0.
- R7: If reset enable is clear, an expiry never drives `sys_rst_o`. The watchdog holds its flags and stays enabled until the next restart.
- R8: While enable is 0, nothing counts and neither `irq_o` nor `sys_rst_o` is asserted, whatever the other fields hold.
- R9: Writing 1 to bit 3 or bit 2 clears the matching flag, and writing 0 leaves it unchanged. The reset flag survives the block's own reset pulse and is cleared otherwise only by power-on reset.
- R10: A write that changes the divider or interval select without bit 0 set keeps the running count. A limit lowered below the count expires on the next divided tick. A raised limit extends the current period.
- R11: With HAS_IRQ = 0, `irq_o` stays low and bit 6 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| req_valid | input | 1 | Access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; the register sits at REG_ADDR |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, combinational, zero unless a read hits the register |
| irq_o | output | 1 | Pre-timeout interrupt |
| sys_rst_o | output | 1 | System reset request |

## Verification
The bench checks the exact expiry edge for every divider step and for several interval steps. A design with the wrong ratio, or one that is off by a single tick, would raise the interrupt on the wrong edge. It measures the delay from warning to reset and the width of the reset pulse. It also checks that enable clears after the pulse while the reset flag stays set, which a design that dropped the flag with its own reset would fail. It changes the limit in the middle of a count without a restart, in both directions. A design that compared only for equality would never expire when the limit was lowered. A design that zeroed the count on every write would expire late when the limit was raised. The bench also confirms that the flags ignore writes of 0, that restart reads back as 0, and that nothing fires while enable is clear, with reset enable off, or when the interrupt option is removed.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   localparam int REG_W = 32;

   // control word bit positions
   localparam int B_KICK    = 0;
   localparam int B_RST_EN  = 1;
   localparam int B_RFLAG   = 2;
   localparam int B_IFLAG   = 3;
   localparam int B_IVAL_LO = 4;
   localparam int B_IRQ_EN  = 6;
   localparam int B_RUN     = 7;
   localparam int B_DIV_LO  = 10;

   typedef enum logic [1:0] {
      PH_COUNT = 2'd0,
      PH_WARN  = 2'd1,
      PH_BITE  = 2'd2,
      PH_HALT  = 2'd3
   } phase_t;

   typedef struct packed {
      logic [1:0] div_sel;
      logic       run;
      logic       irq_en;
      logic [1:0] ival_sel;
      logic       rst_en;
   } wcfg_t;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int REG_ADDR = 32,
   parameter bit HAS_IRQ  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [REG_W-1:0]  req_wdata,
   output logic [REG_W-1:0]  rsp_rdata,
   output wcfg_t             cfg_o,
   output logic              iflag_o,
   output logic              rflag_o,
   output logic              kick_o,
   input  logic              expire_i,
   input  logic              bite_start_i,
   input  logic              bite_done_i
);

   if (ADDR_W < 1 || ADDR_W > 32) begin : g_chk_addr
      $error("wdog_regs: ADDR_W out of range");
   end

   logic hit, wr, rd;
   logic run_q, rst_en_q, ie_q, iflag_q, rflag_q;
   logic [1:0] div_q, ival_q;
   logic [REG_W-1:0] word;
   logic unused_wdata;

   assign hit    = (req_addr == ADDR_W'(REG_ADDR));
   assign wr     = req_valid && req_write && hit;
   assign rd     = req_valid && !req_write && hit;
   assign kick_o = wr && req_wdata[B_KICK];
   assign unused_wdata = ^{req_wdata[REG_W-1:B_DIV_LO+2], req_wdata[B_DIV_LO-1:B_RUN+1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q    <= 2'b00;
         ival_q   <= 2'b00;
         rst_en_q <= 1'b0;
      end else if (wr) begin
         div_q    <= req_wdata[B_DIV_LO +: 2];
         ival_q   <= req_wdata[B_IVAL_LO +: 2];
         rst_en_q <= req_wdata[B_RST_EN];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           run_q <= 1'b0;
      else if (bite_done_i) run_q <= 1'b0;
      else if (wr)          run_q <= req_wdata[B_RUN];
   end

   if (HAS_IRQ) begin : g_ie
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  ie_q <= 1'b0;
         else if (wr) ie_q <= req_wdata[B_IRQ_EN];
      end
   end else begin : g_no_ie
      assign ie_q = 1'b0;
   end

   // write-1-to-clear flags; a hardware set wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iflag_q <= 1'b0;
         rflag_q <= 1'b0;
      end else begin
         if (expire_i)                         iflag_q <= 1'b1;
         else if (wr && req_wdata[B_IFLAG])    iflag_q <= 1'b0;
         if (bite_start_i)                     rflag_q <= 1'b1;
         else if (wr && req_wdata[B_RFLAG])    rflag_q <= 1'b0;
      end
   end

   always_comb begin
      word                  = '0;
      word[B_DIV_LO +: 2]   = div_q;
      word[B_RUN]           = run_q;
      word[B_IRQ_EN]        = ie_q;
      word[B_IVAL_LO +: 2]  = ival_q;
      word[B_IFLAG]         = iflag_q;
      word[B_RFLAG]         = rflag_q;
      word[B_RST_EN]        = rst_en_q;
      rsp_rdata             = rd ? word : '0;
   end

   assign cfg_o = '{div_sel: div_q, run: run_q, irq_en: ie_q, ival_sel: ival_q, rst_en: rst_en_q};
   assign iflag_o = iflag_q;
   assign rflag_o = rflag_q;

   // R5: an expiry always leaves the warning flag set
   a_r5_flag_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
      expire_i |=> iflag_q);

   // R9: the reset flag only falls after a write of 1 to its bit
   a_r9_rflag_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rflag_q) |-> $past(wr && req_wdata[B_RFLAG]));

endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
   parameter int BASE_DIV = 64,
   parameter int STEP01   = 32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_i,
   input  logic [1:0] div_sel_i,
   output logic       base_tick_o,
   output logic       tick_o
);

   localparam int MAXR = 256 * STEP01;
   localparam int DW   = $clog2(MAXR + 1);

   if (BASE_DIV < 1) begin : g_chk_base
      $error("wdog_prescale: BASE_DIV must be at least 1");
   end
   if (STEP01 < 1) begin : g_chk_step
      $error("wdog_prescale: STEP01 must be at least 1");
   end

   // base prescaler: a divide-by-one build needs no counter at all
   if (BASE_DIV == 1) begin : g_nodiv
      assign base_tick_o = !clr_i;
   end else begin : g_div
      localparam int BW = $clog2(BASE_DIV);
      logic [BW-1:0] bcnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            bcnt_q <= '0;
         else if (clr_i)                        bcnt_q <= '0;
         else if (bcnt_q == BW'(BASE_DIV - 1))  bcnt_q <= '0;
         else                                   bcnt_q <= bcnt_q + 1'b1;
      end

      assign base_tick_o = !clr_i && (bcnt_q == BW'(BASE_DIV - 1));

      // R3: a clear always leaves the base counter at zero
      a_r3_base_cleared: assert property (@(posedge clk) disable iff (!rst_n)
         clr_i |=> (bcnt_q == '0));
   end

   logic [DW-1:0] ratio, dcnt_q;
   logic [DW:0]   dnext;
   logic          dwrap;

   always_comb begin
      unique case (div_sel_i)
         2'd0:    ratio = DW'(1);
         2'd1:    ratio = DW'(STEP01);
         2'd2:    ratio = DW'(8 * STEP01);
         default: ratio = DW'(256 * STEP01);
      endcase
   end

   assign dnext = {1'b0, dcnt_q} + 1'b1;
   assign dwrap = (dnext >= {1'b0, ratio});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            dcnt_q <= '0;
      else if (clr_i)        dcnt_q <= '0;
      else if (base_tick_o)  dcnt_q <= dwrap ? '0 : dnext[DW-1:0];
   end

   assign tick_o = base_tick_o && dwrap;

endmodule

// File: rtl/wdog_seq.sv
module wdog_seq
   import wdog_pkg::*;
#(
   parameter int INTERVAL_BASE = 1024,
   parameter int RST_DELAY     = 1024,
   parameter int RST_HOLD      = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_i,
   input  logic       base_tick_i,
   input  logic       tick_i,
   input  logic [1:0] ival_sel_i,
   input  logic       rst_en_i,
   input  logic       run_i,
   output logic       expire_o,
   output logic       bite_start_o,
   output logic       bite_done_o,
   output logic       sys_rst_o
);

   localparam int IMAX = INTERVAL_BASE * 64;
   localparam int IW   = $clog2(IMAX + 1);
   localparam int DLW  = $clog2(RST_DELAY + 1);
   localparam int HW   = $clog2(RST_HOLD + 1);

   if (INTERVAL_BASE < 1) begin : g_chk_ib
      $error("wdog_seq: INTERVAL_BASE must be at least 1");
   end
   if (RST_DELAY < 1 || RST_HOLD < 1) begin : g_chk_rst
      $error("wdog_seq: RST_DELAY and RST_HOLD must be at least 1");
   end

   phase_t         ph_q;
   logic [IW-1:0]  icnt_q, lim;
   logic [DLW-1:0] dly_q;
   logic [HW-1:0]  hcnt_q;
   logic [IW:0]    inext;
   logic [DLW:0]   dnext;
   logic [HW:0]    hnext;
   logic           iwrap, dwrap, hwrap;

   assign lim   = IW'(INTERVAL_BASE) << {ival_sel_i, 1'b0};
   assign inext = {1'b0, icnt_q} + 1'b1;
   assign dnext = {1'b0, dly_q} + 1'b1;
   assign hnext = {1'b0, hcnt_q} + 1'b1;
   // greater-or-equal so that a limit lowered mid-count still expires
   assign iwrap = (inext >= {1'b0, lim});
   assign dwrap = (dnext >= (DLW+1)'(RST_DELAY));
   assign hwrap = (hnext >= (HW+1)'(RST_HOLD));

   assign expire_o     = !clr_i && (ph_q == PH_COUNT) && tick_i && iwrap;
   assign bite_start_o = !clr_i && (ph_q == PH_WARN) && base_tick_i && dwrap && rst_en_i;
   assign bite_done_o  = !clr_i && (ph_q == PH_BITE) && hwrap;
   assign sys_rst_o    = (ph_q == PH_BITE) && run_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_COUNT;
         icnt_q <= '0;
         dly_q  <= '0;
         hcnt_q <= '0;
      end else if (clr_i) begin
         ph_q   <= PH_COUNT;
         icnt_q <= '0;
         dly_q  <= '0;
         hcnt_q <= '0;
      end else begin
         unique case (ph_q)
            PH_COUNT: if (tick_i) begin
               if (iwrap) begin
                  icnt_q <= '0;
                  dly_q  <= '0;
                  ph_q   <= PH_WARN;
               end else begin
                  icnt_q <= inext[IW-1:0];
               end
            end
            PH_WARN: if (base_tick_i) begin
               if (dwrap) begin
                  hcnt_q <= '0;
                  ph_q   <= rst_en_i ? PH_BITE : PH_HALT;
               end else begin
                  dly_q <= dnext[DLW-1:0];
               end
            end
            PH_BITE: begin
               if (hwrap) ph_q   <= PH_HALT;
               else       hcnt_q <= hnext[HW-1:0];
            end
            default: ;
         endcase
      end
   end

   // R3: a restart or disable returns the sequence to a zero count
   a_r3_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (ph_q == PH_COUNT && icnt_q == '0));

   // R7: the reset phase is entered only with reset enable set
   a_r7_bite_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ph_q == PH_BITE) |-> $past(rst_en_i));

   // R6: the pulse counter never passes the hold length
   a_r6_hold_bound: assert property (@(posedge clk) disable iff (!rst_n)
      hcnt_q < HW'(RST_HOLD));

   // R6: a pulse that ends on its own goes to the halted phase
   a_r6_halt_after_bite: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ph_q == PH_BITE) && $past(!clr_i)) |-> (ph_q == PH_HALT));

endmodule

// File: rtl/wdog_core.sv
module wdog_core
   import wdog_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter int REG_ADDR      = 32,
   parameter int BASE_DIV      = 64,
   parameter int STEP01        = 32,
   parameter int INTERVAL_BASE = 1024,
   parameter int RST_DELAY     = 1024,
   parameter int RST_HOLD      = 16,
   parameter bit HAS_IRQ       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic [31:0]       rsp_rdata,
   output logic              irq_o,
   output logic              sys_rst_o
);

   wcfg_t cfg;
   logic  iflag, rflag, kick, clr;
   logic  base_tick, tick, expire, bite_start, bite_done;

   wdog_regs #(
      .ADDR_W   (ADDR_W),
      .REG_ADDR (REG_ADDR),
      .HAS_IRQ  (HAS_IRQ)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_write    (req_write),
      .req_addr     (req_addr),
      .req_wdata    (req_wdata),
      .rsp_rdata    (rsp_rdata),
      .cfg_o        (cfg),
      .iflag_o      (iflag),
      .rflag_o      (rflag),
      .kick_o       (kick),
      .expire_i     (expire),
      .bite_start_i (bite_start),
      .bite_done_i  (bite_done)
   );

   assign clr = kick || !cfg.run;

   wdog_prescale #(
      .BASE_DIV (BASE_DIV),
      .STEP01   (STEP01)
   ) u_pre (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (clr),
      .div_sel_i   (cfg.div_sel),
      .base_tick_o (base_tick),
      .tick_o      (tick)
   );

   wdog_seq #(
      .INTERVAL_BASE (INTERVAL_BASE),
      .RST_DELAY     (RST_DELAY),
      .RST_HOLD      (RST_HOLD)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr_i        (clr),
      .base_tick_i  (base_tick),
      .tick_i       (tick),
      .ival_sel_i   (cfg.ival_sel),
      .rst_en_i     (cfg.rst_en),
      .run_i        (cfg.run),
      .expire_o     (expire),
      .bite_start_o (bite_start),
      .bite_done_o  (bite_done),
      .sys_rst_o    (sys_rst_o)
   );

   if (HAS_IRQ) begin : g_irq
      assign irq_o = iflag && cfg.irq_en && cfg.run;
   end else begin : g_no_irq
      assign irq_o = 1'b0;
   end

   // R6: the reset flag is already set on the first cycle of a reset pulse
   a_r6_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst_o) |-> rflag);

endmodule

// File: tb/wdog_core_test.sv
module wdog_core_test;

   localparam int BD   = 2;
   localparam int S    = 2;
   localparam int IB   = 4;
   localparam int RD   = 3;
   localparam int RH   = 4;
   localparam int AW   = 8;
   localparam int REGA = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid, req_write;
   logic [AW-1:0] req_addr;
   logic [31:0]   req_wdata;
   logic [31:0]   rdata, rdata2;
   logic          irq, sys_rst, irq2, sys_rst2;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   wdog_core #(.ADDR_W(AW), .REG_ADDR(REGA), .BASE_DIV(BD), .STEP01(S),
               .INTERVAL_BASE(IB), .RST_DELAY(RD), .RST_HOLD(RH), .HAS_IRQ(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rdata),
      .irq_o(irq), .sys_rst_o(sys_rst));

   wdog_core #(.ADDR_W(AW), .REG_ADDR(REGA), .BASE_DIV(BD), .STEP01(S),
               .INTERVAL_BASE(IB), .RST_DELAY(RD), .RST_HOLD(RH), .HAS_IRQ(1'b0)) uut_noirq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rdata2),
      .irq_o(irq2), .sys_rst_o(sys_rst2));

   // ---------------- reference model ----------------
   int m_bp, m_dc, m_ic, m_dly, m_hc, m_ph, m_cs, m_is;
   bit m_en, m_ie, m_re, m_if, m_rf;

   function automatic int ratio(input int cs);
      case (cs)
         0: return 1;
         1: return S;
         2: return 8 * S;
         default: return 256 * S;
      endcase
   endfunction

   function automatic int limit(input int is);
      return IB * (4 ** is);
   endfunction

   function automatic int exp_t(input int cs, input int is);
      return BD * ratio(cs) * limit(is);
   endfunction

   function automatic logic [31:0] exp_word();
      logic [31:0] w;
      w = '0;
      w[11:10] = 2'(m_cs);
      w[7] = m_en;
      w[6] = m_ie;
      w[5:4] = 2'(m_is);
      w[3] = m_if;
      w[2] = m_rf;
      w[1] = m_re;
      return w;
   endfunction

   always @(posedge clk) begin : model
      bit wr, rs, clr, bt, tk, ex, bs, bd;
      if (!rst_n) begin
         m_bp = 0; m_dc = 0; m_ic = 0; m_dly = 0; m_hc = 0; m_ph = 0;
         m_cs = 0; m_is = 0; m_en = 0; m_ie = 0; m_re = 0; m_if = 0; m_rf = 0;
      end else begin
         wr  = req_valid && req_write && (req_addr == AW'(REGA));
         rs  = wr && req_wdata[0];
         clr = rs || !m_en;
         bt = 0; tk = 0; ex = 0; bs = 0; bd = 0;
         if (clr) begin
            m_bp = 0; m_dc = 0;
         end else begin
            if (m_bp == BD - 1) begin m_bp = 0; bt = 1; end
            else m_bp++;
            if (bt) begin
               if (m_dc + 1 >= ratio(m_cs)) begin m_dc = 0; tk = 1; end
               else m_dc++;
            end
         end
         if (clr) begin
            m_ph = 0; m_ic = 0; m_dly = 0; m_hc = 0;
         end else begin
            case (m_ph)
               0: if (tk) begin
                  if (m_ic + 1 >= limit(m_is)) begin m_ic = 0; m_dly = 0; m_ph = 1; ex = 1; end
                  else m_ic++;
               end
               1: if (bt) begin
                  if (m_dly + 1 >= RD) begin
                     if (m_re) begin m_ph = 2; m_hc = 0; bs = 1; end
                     else m_ph = 3;
                  end else m_dly++;
               end
               2: if (m_hc + 1 >= RH) begin m_ph = 3; bd = 1; end
                  else m_hc++;
               default: ;
            endcase
         end
         if (wr) begin
            m_cs = int'(req_wdata[11:10]);
            m_is = int'(req_wdata[5:4]);
            m_ie = req_wdata[6];
            m_re = req_wdata[1];
         end
         if (bd) m_en = 0;
         else if (wr) m_en = req_wdata[7];
         if (ex) m_if = 1;
         else if (wr && req_wdata[3]) m_if = 0;
         if (bs) m_rf = 1;
         else if (wr && req_wdata[2]) m_rf = 0;
      end
   end

   // ---------------- checking helpers ----------------
   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R5 irq per cycle", 32'(irq), 32'(m_if && m_ie && m_en));
         chk("R6 sys_rst per cycle", 32'(sys_rst), 32'(m_ph == 2 && m_en));
         chk("R11 irq removed", 32'(irq2), 32'd0);
      end
   end

   task automatic do_write(input logic [31:0] w);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(REGA); req_wdata = w;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
   endtask

   task automatic do_read(output logic [31:0] d, output logic [31:0] d2, output logic [31:0] e);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(REGA);
      #1;
      d = rdata; d2 = rdata2; e = exp_word();
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // restart word that also clears both flags (bits 3, 2, 0)
   function automatic logic [31:0] mk(input int cs, input int is, input bit ie, input bit re, input bit en);
      logic [31:0] w;
      w = 32'h0000_000D;
      w[11:10] = 2'(cs);
      w[5:4] = 2'(is);
      w[6] = ie; w[1] = re; w[7] = en;
      return w;
   endfunction

   task automatic time_to_irq(input logic [31:0] w, output int n);
      do_write(w);
      n = 0;
      while (!irq && n < 20000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] d, d2, e;
      int n, m;
      bit seen;
      req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1
      chk("R1 irq after reset", 32'(irq), 0);
      chk("R1 sys_rst after reset", 32'(sys_rst), 0);
      do_read(d, d2, e);
      chk("R1 reset word", d, 32'h0);

      // R2 and R11
      do_write(mk(1, 0, 1, 0, 1));
      do_read(d, d2, e);
      chk("R2 readback layout", d, 32'h0000_04C0);
      chk("R2 model word", d, e);
      chk("R2 restart bit reads 0", 32'(d[0]), 0);
      chk("R11 irq enable reads 0", 32'(d2[6]), 0);

      // R3: read-modify-write keep-alive
      for (int k = 0; k < 6; k++) begin
         repeat (8) @(negedge clk);
         do_read(d, d2, e);
         do_write(d | 32'h1);
      end
      do_read(d, d2, e);
      chk("R3 keep-alive leaves flag clear", 32'(d[3]), 0);
      chk("R3 irq low under keep-alive", 32'(irq), 0);

      // R4 ladder
      time_to_irq(mk(0, 0, 1, 0, 1), n); chk("R4 timeout div0 ival0", n, exp_t(0, 0));
      do_read(d, d2, e); chk("R5 flag set after expiry", 32'(d[3]), 1);
      time_to_irq(mk(1, 0, 1, 0, 1), n); chk("R4 timeout div1 ival0", n, exp_t(1, 0));
      time_to_irq(mk(1, 1, 1, 0, 1), n); chk("R4 timeout div1 ival1", n, exp_t(1, 1));
      time_to_irq(mk(1, 2, 1, 0, 1), n); chk("R4 timeout div1 ival2", n, exp_t(1, 2));
      time_to_irq(mk(1, 3, 1, 0, 1), n); chk("R4 timeout div1 ival3", n, exp_t(1, 3));
      time_to_irq(mk(2, 0, 1, 0, 1), n); chk("R4 timeout div2 ival0", n, exp_t(2, 0));
      time_to_irq(mk(2, 1, 1, 0, 1), n); chk("R4 timeout div2 ival1", n, exp_t(2, 1));
      time_to_irq(mk(3, 0, 1, 0, 1), n); chk("R4 timeout div3 ival0", n, exp_t(3, 0));

      // R6: warning then reset pulse
      time_to_irq(mk(0, 0, 1, 1, 1), n); chk("R6 warning edge", n, exp_t(0, 0));
      m = 0;
      while (!sys_rst && m < 1000) begin @(negedge clk); m++; end
      chk("R6 warning to reset delay", m, RD * BD);
      m = 0;
      while (sys_rst && m < 1000) begin @(negedge clk); m++; end
      chk("R6 reset pulse length", m, RH);
      do_read(d, d2, e);
      chk("R6 enable cleared, flags kept", d, 32'h0000_004E);
      chk("R8 irq low once disabled", 32'(irq), 0);

      // R9: write-1-to-clear
      do_write(32'h0); do_read(d, d2, e);
      chk("R9 zero write keeps flags", d, 32'h0000_000C);
      do_write(32'h8); do_read(d, d2, e);
      chk("R9 clear interrupt flag only", d, 32'h0000_0004);
      do_write(32'h4); do_read(d, d2, e);
      chk("R9 clear reset flag", d, 32'h0);

      // R7: expiry with reset disabled
      do_write(mk(0, 0, 1, 0, 1));
      seen = 0;
      for (int k = 0; k < 60; k++) begin @(negedge clk); if (sys_rst) seen = 1; end
      chk("R7 no reset pulse", 32'(seen), 0);
      do_read(d, d2, e);
      chk("R7 halted but enabled", d, 32'h0000_00C8);

      // R8: disabled block stays silent
      do_write(32'h0000_004F);
      seen = 0;
      for (int k = 0; k < 100; k++) begin @(negedge clk); if (irq || sys_rst) seen = 1; end
      chk("R8 nothing fires while disabled", 32'(seen), 0);
      do_read(d, d2, e);
      chk("R8 no flag while disabled", d, 32'h0000_0042);

      // R10: lower the limit mid-count without restart
      do_write(mk(1, 2, 1, 0, 1));
      repeat (100) @(negedge clk);
      do_write(32'h0000_04C0);
      n = 0;
      while (!irq && n < 1000) begin @(negedge clk); n++; end
      chk("R10 lowered limit expires on next tick", 32'(n >= 1 && n <= BD * S), 1);

      // R10: raise the limit mid-count without restart
      do_write(mk(1, 0, 1, 0, 1));
      repeat (6) @(negedge clk);
      do_write(32'h0000_04D0);
      n = 0;
      while (!irq && n < 1000) begin @(negedge clk); n++; end
      chk("R10 raised limit extends period", n, exp_t(1, 1) - 8);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule